// File: doc/BRIEF.md
# Single-Operand Negate, Clear and Complement Unit

This block performs four one-operand arithmetic operations on a data value: negate, negate with the extend flag folded in as a borrow, clear, and bitwise complement. The operand can be a byte, a word or a long word. Only the low bits of the selected size are processed. The bits above that size are merged back unchanged. Alongside the result, the unit produces a new five-bit condition-code set and the number of bus-clock cycles the operation is charged.

An execution pipeline uses the unit as follows. It presents the operand, the operation type, the size code, a flag that says whether the operand came from memory, and the current condition codes. It then raises a start strobe for one cycle. One clock edge later, the registered result, flags and cycle count appear together with a one-cycle done pulse. These outputs hold until the next start.

The type encoding is 0 for negate-with-extend, 1 for clear, 2 for negate and 3 for complement. The size encoding is 0 for byte, 1 for word, 2 for long and 3 for illegal. On every flag port, bit 4 is X, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.

Top module: `unary_alu`

## Requirements
- R1: A start with size code 3 sets `sizeErrOut` to 1 in the done cycle. In that case `resultOut` equals the operand, `flagsOut` equals the incoming flags and `cyclesOut` is 0. Legal sizes give `sizeErrOut` of 0.
- R2: Type 0 (negate-with-extend) returns 0 minus the sized operand minus X. N is the result's top bit, V is signed overflow, C is 1 when the operand or X is nonzero, and X takes the value of C. Z is 0 when the sized result is nonzero and otherwise keeps its incoming value.
- R3: Type 1 (clear) returns a sized result of zero with N=0, Z=1, V=0 and C=0.
- R4: Type 3 (complement) returns the bitwise inverse of the sized operand. N and Z are set from that result, and V and C are 0.
- R5: Type 2 (negate) returns 0 minus the sized operand. N and Z come from the result, V is signed overflow, C is 1 when the operand is nonzero, and X takes the value of C.
- R6: Clear and complement leave X (bit 4) at its incoming value.
- R7: For byte and word sizes, result bits above the operand size equal the input operand bits.
- R8: `cyclesOut` is 4 for byte and word and 6 for long. Both values double when `memOperand` is 1.
- R9: `doneOut` is high for exactly the one cycle after a start cycle. The outputs keep their values until the next start.
- R10: After reset, `doneOut`, `sizeErrOut`, `resultOut`, `flagsOut` and `cyclesOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | One-cycle strobe that launches an operation |
| opType | input | 2 | Operation: 0 negx, 1 clear, 2 neg, 3 complement |
| sizeCode | input | 2 | Size: 0 byte, 1 word, 2 long, 3 illegal |
| memOperand | input | 1 | Operand came from memory (doubles the cycle cost) |
| operandIn | input | 32 | Operand value |
| flagsIn | input | 5 | Current flags {X,N,Z,V,C} |
| doneOut | output | 1 | Result valid pulse |
| resultOut | output | 32 | Sized result merged into the operand's upper bits |
| flagsOut | output | 5 | New flags {X,N,Z,V,C} |
| cyclesOut | output | 4 | Cycle cost of the operation |
| sizeErrOut | output | 1 | Illegal size was requested |

## Verification
Suppose the size lane is selected wrongly, or a stale control strobe is captured. The result or the flags are then wrong in the very done cycle of the affected start, because every output is a single register stage away from the inputs. A sticky-Z fault appears only when negate-with-extend produces zero. The sweep therefore crosses every operand pattern with both incoming Z values and both X values. Hold faults appear on the idle cycle after each done, where the outputs are compared again.

// File: rtl/unary_pkg.sv
package unary_pkg;

  typedef enum logic [1:0] {
    OP_NEGX = 2'd0,
    OP_CLR  = 2'd1,
    OP_NEG  = 2'd2,
    OP_NOT  = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } sizeKind_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  typedef struct packed {
    logic      load;
    logic      bad;
    opKind_e   kind;
    logic [1:0] lane;
  } dpCtrl_t;

endpackage

// File: rtl/unary_ctrl.sv
module unary_ctrl
  import unary_pkg::*;
#(
  parameter int CYC_W     = 4,
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startIn,
  input  logic [1:0]       opType,
  input  logic [1:0]       sizeCode,
  input  logic             memOperand,
  output dpCtrl_t          ctrlOut,
  output logic             doneOut,
  output logic             errOut,
  output logic [CYC_W-1:0] cyclesOut
);

  localparam logic [CYC_W-1:0] SHORT_V = CYC_W'(SHORT_CYC);
  localparam logic [CYC_W-1:0] LONG_V  = CYC_W'(LONG_CYC);

  logic             isBad;
  logic [CYC_W-1:0] baseCyc;
  logic [CYC_W-1:0] costCyc;

  always_comb begin
    isBad        = (sizeKind_e'(sizeCode) == SZ_BAD);
    ctrlOut.load = startIn;
    ctrlOut.bad  = isBad;
    ctrlOut.kind = opKind_e'(opType);
    ctrlOut.lane = sizeCode;
    baseCyc      = (sizeKind_e'(sizeCode) == SZ_LONG) ? LONG_V : SHORT_V;
    costCyc      = memOperand ? (baseCyc << 1) : baseCyc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doneOut   <= 1'b0;
      errOut    <= 1'b0;
      cyclesOut <= '0;
    end else begin
      doneOut <= startIn;
      if (startIn) begin
        errOut    <= isBad;
        cyclesOut <= isBad ? '0 : costCyc;
      end
    end
  end

  // R9: a start is always answered by a done on the next cycle
  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    startIn |=> doneOut);
  // R9: without a start there is no done on the next cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !startIn |=> !doneOut);
  // R1: an illegal size is flagged and charges nothing
  assert_bad_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (startIn && sizeCode == 2'd3) |=> (errOut && cyclesOut == '0));
  // R8: a long register operand costs the long count
  assert_long_cost_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (startIn && sizeCode == 2'd2 && !memOperand) |=> (cyclesOut == LONG_V));

endmodule

// File: rtl/unary_dp.sv
module unary_dp
  import unary_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           ctrlIn,
  input  logic [DATA_W-1:0] operandIn,
  input  ccr_t              flagsIn,
  output logic [DATA_W-1:0] resultOut,
  output ccr_t              flagsOut
);

  localparam int NUM_LANES = $clog2(DATA_W / 8) + 1;

  logic [DATA_W-1:0] laneRes   [NUM_LANES];
  ccr_t              laneFlags [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    localparam int LW = 8 << g;

    logic [LW-1:0] aVal;
    logic [LW-1:0] rVal;
    logic [LW:0]   diff;
    logic          borrowIn;
    logic          isZero;
    ccr_t          fl;

    always_comb begin
      aVal     = operandIn[LW-1:0];
      borrowIn = (ctrlIn.kind == OP_NEGX) && flagsIn.x;
      diff     = {(LW+1){1'b0}} - {1'b0, aVal} - {{LW{1'b0}}, borrowIn};
      unique case (ctrlIn.kind)
        OP_CLR:  rVal = '0;
        OP_NOT:  rVal = ~aVal;
        default: rVal = diff[LW-1:0];
      endcase
      isZero = (rVal == '0);
      fl     = flagsIn;
      unique case (ctrlIn.kind)
        OP_CLR: begin
          fl.n = 1'b0; fl.z = 1'b1; fl.v = 1'b0; fl.c = 1'b0;
        end
        OP_NOT: begin
          fl.n = rVal[LW-1]; fl.z = isZero; fl.v = 1'b0; fl.c = 1'b0;
        end
        OP_NEG: begin
          fl.n = rVal[LW-1]; fl.z = isZero;
          fl.v = aVal[LW-1] & rVal[LW-1];
          fl.c = diff[LW];   fl.x = diff[LW];
        end
        default: begin
          fl.n = rVal[LW-1];
          fl.z = isZero & flagsIn.z;
          fl.v = aVal[LW-1] & rVal[LW-1];
          fl.c = diff[LW];   fl.x = diff[LW];
        end
      endcase
      laneFlags[g] = fl;
    end

    if (LW < DATA_W) begin : gMerge
      assign laneRes[g] = {operandIn[DATA_W-1:LW], rVal};
    end else begin : gFull
      assign laneRes[g] = rVal;
    end
  end

  logic [DATA_W-1:0] pickRes;
  ccr_t              pickFlags;

  always_comb begin
    pickRes   = operandIn;
    pickFlags = flagsIn;
    for (int k = 0; k < NUM_LANES; k++) begin
      if (!ctrlIn.bad && ctrlIn.lane == 2'(k)) begin
        pickRes   = laneRes[k];
        pickFlags = laneFlags[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resultOut <= '0;
      flagsOut  <= '0;
    end else if (ctrlIn.load) begin
      resultOut <= pickRes;
      flagsOut  <= pickFlags;
    end
  end

  // R3: clear always lands on the fixed flag pattern
  assert_clear_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlIn.load && !ctrlIn.bad && ctrlIn.kind == OP_CLR)
      |=> (!flagsOut.n && flagsOut.z && !flagsOut.v && !flagsOut.c));
  // R6: clear and complement keep X
  assert_x_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlIn.load && !ctrlIn.bad && (ctrlIn.kind == OP_CLR || ctrlIn.kind == OP_NOT))
      |=> (flagsOut.x == $past(flagsIn.x)));
  // R2: Z can never be raised by negate-with-extend
  assert_sticky_z_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlIn.load && !ctrlIn.bad && ctrlIn.kind == OP_NEGX && !flagsIn.z)
      |=> !flagsOut.z);
  // R7: byte results keep the operand's upper bits
  assert_upper_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlIn.load && !ctrlIn.bad && ctrlIn.lane == 2'd0)
      |=> (resultOut[DATA_W-1:8] == $past(operandIn[DATA_W-1:8])));
  // R1: an illegal size leaves the flags as they came in
  assert_bad_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlIn.load && ctrlIn.bad) |=> (flagsOut == $past(flagsIn)));

endmodule

// File: rtl/unary_alu.sv
module unary_alu
  import unary_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CYC_W     = 4,
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startIn,
  input  logic [1:0]        opType,
  input  logic [1:0]        sizeCode,
  input  logic              memOperand,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [4:0]        flagsIn,
  output logic              doneOut,
  output logic [DATA_W-1:0] resultOut,
  output logic [4:0]        flagsOut,
  output logic [CYC_W-1:0]  cyclesOut,
  output logic              sizeErrOut
);

  dpCtrl_t dpCtrl;
  ccr_t    flagsReg;

  unary_ctrl #(
    .CYC_W    (CYC_W),
    .SHORT_CYC(SHORT_CYC),
    .LONG_CYC (LONG_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startIn   (startIn),
    .opType    (opType),
    .sizeCode  (sizeCode),
    .memOperand(memOperand),
    .ctrlOut   (dpCtrl),
    .doneOut   (doneOut),
    .errOut    (sizeErrOut),
    .cyclesOut (cyclesOut)
  );

  unary_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrlIn   (dpCtrl),
    .operandIn(operandIn),
    .flagsIn  (ccr_t'(flagsIn)),
    .resultOut(resultOut),
    .flagsOut (flagsReg)
  );

  assign flagsOut = flagsReg;

endmodule

// File: tb/unary_alu_tb.sv
module unary_alu_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        startIn = 1'b0;
  logic [1:0]  opType = '0;
  logic [1:0]  sizeCode = '0;
  logic        memOperand = 1'b0;
  logic [31:0] operandIn = '0;
  logic [4:0]  flagsIn = '0;
  logic        doneOut;
  logic [31:0] resultOut;
  logic [4:0]  flagsOut;
  logic [3:0]  cyclesOut;
  logic        sizeErrOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  unary_alu u_dut (
    .clk(clk), .rst_n(rst_n), .startIn(startIn), .opType(opType),
    .sizeCode(sizeCode), .memOperand(memOperand), .operandIn(operandIn),
    .flagsIn(flagsIn), .doneOut(doneOut), .resultOut(resultOut),
    .flagsOut(flagsOut), .cyclesOut(cyclesOut), .sizeErrOut(sizeErrOut)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string opReq(input int t);
    case (t)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic runOne(input int t, input int sz, input bit m,
                        input logic [31:0] op, input logic [4:0] f);
    logic [31:0] expRes;
    logic [4:0]  expFl;
    int          expCyc;
    bit          expErr;
    longint      w, mask, a, sa, ex, r, half;
    bit          xin, n, z, v, c, x;
    logic [31:0] heldRes;
    logic [4:0]  heldFl;
    if (sz == 3) begin
      expRes = op; expFl = f; expCyc = 0; expErr = 1'b1;
    end else begin
      w    = 64'd8 << sz;
      mask = (64'd1 << w) - 1;
      half = 64'd1 << (w - 1);
      a    = longint'(op) & mask;
      sa   = (a >= half) ? a - (64'd1 << w) : a;
      xin  = f[4];
      x = f[4]; n = f[3]; z = f[2]; v = f[1]; c = f[0];
      case (t)
        1: begin r = 0; n = 0; z = 1; v = 0; c = 0; end
        3: begin r = (~a) & mask; n = ((r >> (w-1)) & 1) != 0; z = (r == 0); v = 0; c = 0; end
        default: begin
          ex = -sa - ((t == 0) ? longint'(xin) : 0);
          r  = ex & mask;
          n  = ((r >> (w-1)) & 1) != 0;
          v  = (ex > half - 1) || (ex < -half);
          c  = (a + ((t == 0) ? longint'(xin) : 0)) != 0;
          x  = c;
          z  = (t == 0) ? ((r == 0) ? f[2] : 1'b0) : (r == 0);
        end
      endcase
      expRes = 32'((longint'(op) & ~mask) | r);
      expFl  = {x, n, z, v, c};
      expCyc = ((sz == 2) ? 6 : 4) * (m ? 2 : 1);
      expErr = 1'b0;
    end
    @(negedge clk);
    opType = 2'(t); sizeCode = 2'(sz); memOperand = m;
    operandIn = op; flagsIn = f; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check("R9 done", longint'(doneOut), 1);
    check("R1 err", longint'(sizeErrOut), longint'(expErr));
    if (sz == 3) begin
      check("R1 result", longint'(resultOut), longint'(expRes));
      check("R1 flags", longint'(flagsOut), longint'(expFl));
    end else begin
      check({opReq(t), " result"}, longint'(resultOut), longint'(expRes));
      check({opReq(t), " flags"}, longint'(flagsOut), longint'(expFl));
      if (sz < 2) check("R7 upper", longint'(resultOut[31:16]), longint'(op[31:16]));
      if (t == 1 || t == 3) check("R6 x", longint'(flagsOut[4]), longint'(f[4]));
    end
    check("R8 cycles", longint'(cyclesOut), longint'(expCyc));
    heldRes = resultOut; heldFl = flagsOut;
    operandIn = ~op; flagsIn = ~f;
    @(negedge clk);
    check("R9 pulse", longint'(doneOut), 0);
    check("R9 hold", longint'({heldRes, heldFl}), longint'({resultOut, flagsOut}));
  endtask

  initial begin
    logic [31:0] pats [12];
    pats = '{32'h0, 32'h1, 32'h80, 32'hFF, 32'h7F, 32'h8000, 32'hFFFF,
             32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0100, 32'h7FFF_FFFF};
    repeat (3) @(negedge clk);
    check("R10 done", longint'(doneOut), 0);
    check("R10 err", longint'(sizeErrOut), 0);
    check("R10 result", longint'(resultOut), 0);
    check("R10 flags", longint'(flagsOut), 0);
    check("R10 cycles", longint'(cyclesOut), 0);
    rst_n = 1'b1;
    for (int t = 0; t < 4; t++)
      for (int sz = 0; sz < 4; sz++)
        for (int m = 0; m < 2; m++)
          for (int fi = 0; fi < 32; fi++)
            for (int p = 0; p < 12; p++)
              runOne(t, sz, m[0], pats[p], 5'(fi));
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule